// File: doc/BRIEF.md
# Charger Status Interrupt and Dead-Battery Timer

This block holds the event-pending state of a USB charger detector and drives its interrupt pin. It watches three sources:
- a debounced VBUS-present level,
- a dead-battery-charge mode flag, which it produces itself,
- a data-contact-timeout flag supplied by the detection controller.

A change on any source sets a pending bit. Each pending bit stays set until software reads the status register. The pin shows the pending state only while the global enable is set, and a polarity control selects its asserted level.

The dead-battery mode is entered on a start request from the detection controller. While the mode is active, a long charge timer runs, 45 minutes at the default clock. Software ends the mode early by setting an exit bit. Leaving the mode this way keeps charging enabled. The exit bit clears itself once the battery reports that it has recovered to the dead-battery threshold. If the timer expires first, the block leaves the mode by itself, withdraws charging and sends a one-cycle timeout pulse to the detection controller. The register bus is outside this block: it sees a read strobe, a write strobe for the exit bit and the control bits directly.

Top module: `chg_irq_ctl`

## Requirements
- R1: After reset:
  - `irq_pend` is 000.
  - `vbus_ok`, `db_mode`, `db_exit_bit`, `chg_keep_en` and `db_timeout` are 0.
  - With `irq_en`=0 and `irq_pol`=0, `irq_pin` is 1.
- R2: `vbus_ok` takes the value of `vbus_raw` only after `vbus_raw` has differed from `vbus_ok` for VBUS_DEB_CYC consecutive cycles, counted after SYNC_STAGES synchronizer flops. A shorter excursion leaves `vbus_ok` unchanged.
- R3: Every change of `vbus_ok`, rising or falling, sets `irq_pend[0]` two cycles later.
- R4: `irq_pend[1]` is set only when `db_mode` rises. `irq_pend[2]` is set only when `dcd_to_flag` rises. A falling edge of either source sets nothing.
- R5: A cycle with `stat_rd`=1 clears all pending bits, except a bit whose event arrives in that same cycle; that bit stays set.
- R6: With `irq_en`=0 the pin sits at its inactive level, and the pending bits are kept.
- R7: The pin is asserted when `irq_en`=1 and any pending bit is set. With `irq_pol`=0 the asserted level is 0; with `irq_pol`=1 it is 1. The inactive level is the opposite.
- R8: After `db_start` is sampled, `db_mode` and `chg_keep_en` go to 1. `db_mode` stays 1 for exactly DB_TIMEOUT_CYC cycles. It then clears, `chg_keep_en` clears, and `db_timeout` is 1 for exactly one cycle.
- R9: A `db_exit_wr` pulse sets `db_exit_bit`. One cycle later `db_mode` clears, the timer stops with no timeout pulse, and `chg_keep_en` stays 1.
- R10: `bat_recovered`=1 clears `db_exit_bit`, and takes precedence over a `db_exit_wr` in the same cycle.
- R11: While `db_exit_bit`=1 a `db_start` request is ignored. Once the bit is clear, a start is accepted again.
- R12: A falling edge of `vbus_ok` clears `chg_keep_en` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_raw | input | 1 | Undebounced VBUS comparator output |
| dcd_to_flag | input | 1 | Data-contact-timeout flag from the detection controller |
| stat_rd | input | 1 | One-cycle strobe: the status register is being read |
| irq_en | input | 1 | Global interrupt enable |
| irq_pol | input | 1 | Pin polarity, 1 = active high |
| db_start | input | 1 | Request to enter dead-battery charge mode |
| db_exit_wr | input | 1 | Write strobe that sets the exit bit |
| bat_recovered | input | 1 | Battery has reached the dead-battery threshold |
| irq_pin | output | 1 | Interrupt pin level |
| irq_pend | output | 3 | Pending events: [0] VBUS, [1] dead-battery entry, [2] data-contact timeout |
| vbus_ok | output | 1 | Debounced VBUS-present level |
| db_mode | output | 1 | Dead-battery charge mode active |
| db_exit_bit | output | 1 | Exit bit as readable by software |
| chg_keep_en | output | 1 | Charging enabled by the dead-battery path |
| db_timeout | output | 1 | One-cycle pulse on timer expiry |

## Verification
The following are checked on every cycle:
- A pending bit never drops without a read.
- The pin sits at its inactive level whenever the enable is low, and is asserted whenever the enable is high and an event is pending.
- The timeout pulse lasts one cycle and coincides with the end of the mode.
- A recovered battery clears the exit bit.
- The mode never starts while the exit bit is set.

Other behaviour only the bench scenarios can show:
- The exact debounce length and glitch rejection.
- Which edge of each source raises an event.
- An event surviving a coincident read.
- The full timer length.
- Charging staying enabled after an early exit, and being withdrawn on VBUS removal.

// File: rtl/chgirq_pkg.sv
package chgirq_pkg;

   // Event source positions inside the pending vector (software decodes these)
   localparam int unsigned SRC_VBUS = 0;
   localparam int unsigned SRC_DBM  = 1;
   localparam int unsigned SRC_DCD  = 2;
   localparam int unsigned NUM_SRC  = 3;

   // Per-source edge selection: 1 = any change raises an event, 0 = rising only
   localparam logic [NUM_SRC-1:0] SRC_ANY_EDGE = 3'b001;

   // Width of a counter that must reach value n-1
   function automatic int unsigned cnt_width(input longint unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/chgirq_sync.sv
module chgirq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= d;
               for (int k = 1; k < STAGES; k++) begin
                  chain_q[k] <= chain_q[k-1];
               end
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/chgirq_debounce.sv
module chgirq_debounce
   import chgirq_pkg::*;
#(
   parameter int unsigned HOLD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl
);
   localparam int unsigned CW = cnt_width(HOLD_CYC);
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

   logic [CW-1:0] hold_cnt;
   logic          lvl_q;

   // The counter runs only while the input disagrees with the held level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         lvl_q    <= 1'b0;
      end else if (d == lvl_q) begin
         hold_cnt <= '0;
      end else if (hold_cnt == LAST) begin
         lvl_q    <= d;
         hold_cnt <= '0;
      end else begin
         hold_cnt <= hold_cnt + 1'b1;
      end
   end

   assign lvl = lvl_q;
endmodule

// File: rtl/chgirq_dbtimer.sv
module chgirq_dbtimer
   import chgirq_pkg::*;
#(
   parameter longint unsigned TIMEOUT_CYC = 64'd675000000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic exit_wr,
   input  logic bat_ok,
   input  logic vbus_lvl,
   output logic mode,
   output logic exit_bit,
   output logic chg_keep,
   output logic timeout
);
   localparam int unsigned TW = cnt_width(TIMEOUT_CYC);
   localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

   logic [TW-1:0] tmr_q;
   logic          mode_q, exit_q, chg_q, to_q, vb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q  <= '0;
         mode_q <= 1'b0;
         exit_q <= 1'b0;
         chg_q  <= 1'b0;
         to_q   <= 1'b0;
         vb_q   <= 1'b0;
      end else begin
         to_q <= 1'b0;
         vb_q <= vbus_lvl;

         // Recovery of the battery wins over a software write
         if (bat_ok) begin
            exit_q <= 1'b0;
         end else if (exit_wr) begin
            exit_q <= 1'b1;
         end

         if (mode_q) begin
            if (exit_q) begin
               mode_q <= 1'b0;
               tmr_q  <= '0;
            end else if (tmr_q == LAST) begin
               mode_q <= 1'b0;
               tmr_q  <= '0;
               to_q   <= 1'b1;
               chg_q  <= 1'b0;
            end else begin
               tmr_q <= tmr_q + 1'b1;
            end
         end else if (start && !exit_q) begin
            mode_q <= 1'b1;
            tmr_q  <= '0;
            chg_q  <= 1'b1;
         end

         if (vb_q && !vbus_lvl) begin
            chg_q <= 1'b0;
         end
      end
   end

   assign mode     = mode_q;
   assign exit_bit = exit_q;
   assign chg_keep = chg_q;
   assign timeout  = to_q;
endmodule

// File: rtl/chgirq_evlatch.sv
module chgirq_evlatch #(
   parameter int unsigned       NSRC     = 3,
   parameter logic [NSRC-1:0]   ANY_EDGE = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic            rd_clr,
   output logic [NSRC-1:0] pend
);
   logic [NSRC-1:0] src_q, prev_q, ev, pend_q;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         if (ANY_EDGE[i]) begin : g_any
            assign ev[i] = src_q[i] ^ prev_q[i];
         end else begin : g_rise
            assign ev[i] = src_q[i] & ~prev_q[i];
         end
      end
   endgenerate

   // New events are merged after the read clear, so none is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         src_q  <= src;
         prev_q <= src_q;
         pend_q <= (rd_clr ? '0 : pend_q) | ev;
      end
   end

   assign pend = pend_q;
endmodule

// File: rtl/chg_irq_ctl.sv
module chg_irq_ctl
   import chgirq_pkg::*;
#(
   parameter int unsigned     SYNC_STAGES    = 2,
   parameter int unsigned     VBUS_DEB_CYC   = 7500000,
   parameter longint unsigned DB_TIMEOUT_CYC = 64'd675000000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vbus_raw,
   input  logic       dcd_to_flag,
   input  logic       stat_rd,
   input  logic       irq_en,
   input  logic       irq_pol,
   input  logic       db_start,
   input  logic       db_exit_wr,
   input  logic       bat_recovered,
   output logic       irq_pin,
   output logic [2:0] irq_pend,
   output logic       vbus_ok,
   output logic       db_mode,
   output logic       db_exit_bit,
   output logic       chg_keep_en,
   output logic       db_timeout
);
   generate
      if (VBUS_DEB_CYC < 2) begin : g_bad_deb
         $error("VBUS_DEB_CYC must be at least 2");
      end
      if (DB_TIMEOUT_CYC < 4) begin : g_bad_tmo
         $error("DB_TIMEOUT_CYC must be at least 4");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic               vbus_s, vbus_lvl, mode_w;
   logic [NUM_SRC-1:0] srcs, pend_w;
   logic               asserted;

   chgirq_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(vbus_raw), .q(vbus_s)
   );

   chgirq_debounce #(.HOLD_CYC(VBUS_DEB_CYC)) deb_i (
      .clk(clk), .rst_n(rst_n), .d(vbus_s), .lvl(vbus_lvl)
   );

   chgirq_dbtimer #(.TIMEOUT_CYC(DB_TIMEOUT_CYC)) tmr_i (
      .clk(clk), .rst_n(rst_n), .start(db_start), .exit_wr(db_exit_wr),
      .bat_ok(bat_recovered), .vbus_lvl(vbus_lvl), .mode(mode_w),
      .exit_bit(db_exit_bit), .chg_keep(chg_keep_en), .timeout(db_timeout)
   );

   always_comb begin
      srcs           = '0;
      srcs[SRC_VBUS] = vbus_lvl;
      srcs[SRC_DBM]  = mode_w;
      srcs[SRC_DCD]  = dcd_to_flag;
   end

   chgirq_evlatch #(.NSRC(NUM_SRC), .ANY_EDGE(SRC_ANY_EDGE)) evl_i (
      .clk(clk), .rst_n(rst_n), .src(srcs), .rd_clr(stat_rd), .pend(pend_w)
   );

   assign asserted = irq_en & (|pend_w);
   assign irq_pin  = irq_pol ? asserted : ~asserted;
   assign irq_pend = pend_w;
   assign vbus_ok  = vbus_lvl;
   assign db_mode  = mode_w;
endmodule

// File: rtl/chgirq_chk.sv
module chgirq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stat_rd,
   input logic       irq_en,
   input logic       irq_pol,
   input logic       db_start,
   input logic       bat_recovered,
   input logic       irq_pin,
   input logic [2:0] irq_pend,
   input logic       db_mode,
   input logic       db_exit_bit,
   input logic       db_timeout
);
   // R5
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> ((irq_pend & $past(irq_pend)) == $past(irq_pend)));

   // R6
   pin_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> (irq_pin == !irq_pol));

   // R7
   pin_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && (irq_pend != 3'b000)) |-> (irq_pin == irq_pol));

   // R8
   tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_timeout |=> !db_timeout);

   // R8
   tmo_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_timeout |-> (!db_mode && $past(db_mode)));

   // R10
   exit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bat_recovered |=> !db_exit_bit);

   // R11
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (db_exit_bit && !db_mode) |=> !db_mode);
endmodule

bind chg_irq_ctl chgirq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .irq_en(irq_en),
   .irq_pol(irq_pol), .db_start(db_start), .bat_recovered(bat_recovered),
   .irq_pin(irq_pin), .irq_pend(irq_pend), .db_mode(db_mode),
   .db_exit_bit(db_exit_bit), .db_timeout(db_timeout)
);

// File: tb/chg_irq_ctl_tb_top.sv
module chg_irq_ctl_tb_top;
   localparam int unsigned SYNC = 2;
   localparam int unsigned DEB  = 8;
   localparam int unsigned DBT  = 200;

   // {have_pend, irq_en, irq_pol, expected pin}
   localparam logic [3:0] PIN_VEC [8] = '{
      4'b0001, 4'b0101, 4'b0110, 4'b0010,
      4'b1001, 4'b1100, 4'b1111, 4'b1010
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vbus_raw = 0, dcd_to_flag = 0, stat_rd = 0, irq_en = 0, irq_pol = 0;
   logic db_start = 0, db_exit_wr = 0, bat_recovered = 0;
   logic irq_pin, vbus_ok, db_mode, db_exit_bit, chg_keep_en, db_timeout;
   logic [2:0] irq_pend;

   int checks = 0, fails = 0, to_cnt = 0, to_seen = 0;
   bit done = 0;

   always #2 clk = ~clk;

   chg_irq_ctl #(.SYNC_STAGES(SYNC), .VBUS_DEB_CYC(DEB), .DB_TIMEOUT_CYC(DBT)) dut_i (
      .clk(clk), .rst_n(rst_n), .vbus_raw(vbus_raw), .dcd_to_flag(dcd_to_flag),
      .stat_rd(stat_rd), .irq_en(irq_en), .irq_pol(irq_pol), .db_start(db_start),
      .db_exit_wr(db_exit_wr), .bat_recovered(bat_recovered), .irq_pin(irq_pin),
      .irq_pend(irq_pend), .vbus_ok(vbus_ok), .db_mode(db_mode),
      .db_exit_bit(db_exit_bit), .chg_keep_en(chg_keep_en), .db_timeout(db_timeout)
   );

   always @(posedge clk) if (rst_n && db_timeout) to_cnt++;

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic rd_clear();
      stat_rd = 1; tick(1); stat_rd = 0;
   endtask

   task automatic dcd_rise();
      dcd_to_flag = 0; tick(2); dcd_to_flag = 1; tick(2);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic have_pend;
      tick(3);
      rst_n = 1; tick(1);
      // R1 reset state
      chk("R1 pend", irq_pend, 3'b000);
      chk("R1 pin", irq_pin, 1'b1);
      chk("R1 flags", {vbus_ok, db_mode, db_exit_bit, chg_keep_en, db_timeout}, 5'b0);

      // R6/R7 pin table
      have_pend = 0;
      for (int i = 0; i < 8; i++) begin
         if (PIN_VEC[i][3] && !have_pend) begin dcd_rise(); have_pend = 1; end
         if (!PIN_VEC[i][3] && have_pend) begin rd_clear(); have_pend = 0; end
         irq_en = PIN_VEC[i][2]; irq_pol = PIN_VEC[i][1];
         tick(1);
         chk("R7 pin level", irq_pin, PIN_VEC[i][0]);
         if (PIN_VEC[i][3]) chk("R6 pend kept", irq_pend, 3'b100);
      end
      rd_clear(); dcd_to_flag = 0; irq_en = 1; irq_pol = 1; tick(3);
      chk("R4 dcd fall no event", irq_pend, 3'b000);

      // R2/R3 debounce and VBUS events
      vbus_raw = 1; tick(DEB + SYNC - 1);
      chk("R2 not yet", vbus_ok, 1'b0);
      tick(1);
      chk("R2 after hold", vbus_ok, 1'b1);
      tick(2);
      chk("R3 rise event", irq_pend, 3'b001);
      rd_clear();
      vbus_raw = 0; tick(DEB - 1); vbus_raw = 1; tick(DEB + SYNC + 2);
      chk("R2 glitch ignored", vbus_ok, 1'b1);
      chk("R2 glitch no event", irq_pend, 3'b000);
      vbus_raw = 0; tick(DEB + SYNC + 2);
      chk("R2 fall", vbus_ok, 1'b0);
      chk("R3 fall event", irq_pend, 3'b001);
      rd_clear();

      // R4 dcd rising event
      dcd_rise();
      chk("R4 dcd rise", irq_pend, 3'b100);
      rd_clear(); dcd_to_flag = 0; tick(2);

      // R5 event coincident with read
      dcd_to_flag = 1; tick(1);
      stat_rd = 1; tick(1); stat_rd = 0;
      chk("R5 coincident kept", irq_pend, 3'b100);
      rd_clear();
      chk("R5 read clears", irq_pend, 3'b000);
      dcd_to_flag = 0; tick(2);

      // R8 full timer run
      db_start = 1; tick(1); db_start = 0;
      chk("R8 mode on", {db_mode, chg_keep_en}, 2'b11);
      tick(2);
      chk("R4 db rise event", irq_pend, 3'b010);
      rd_clear();
      tick(DBT - 4);
      chk("R8 still running", db_mode, 1'b1);
      tick(1);
      chk("R8 expired", {db_mode, chg_keep_en, db_timeout}, 3'b001);
      tick(1);
      chk("R8 pulse one cycle", db_timeout, 1'b0);
      tick(2);
      chk("R4 db fall no event", irq_pend, 3'b000);

      // R9 early exit
      db_start = 1; tick(1); db_start = 0;
      tick(5);
      db_exit_wr = 1; tick(1); db_exit_wr = 0;
      chk("R9 exit bit set", db_exit_bit, 1'b1);
      tick(1);
      chk("R9 mode cleared", db_mode, 1'b0);
      chk("R9 charge kept", chg_keep_en, 1'b1);
      to_seen = to_cnt;
      tick(DBT + 10);
      chk("R9 no timeout", to_cnt, to_seen);

      // R11 start blocked by exit bit
      db_start = 1; tick(1); db_start = 0; tick(1);
      chk("R11 start ignored", db_mode, 1'b0);

      // R10 recovery beats write
      bat_recovered = 1; db_exit_wr = 1; tick(1);
      bat_recovered = 0; db_exit_wr = 0;
      chk("R10 recovery wins", db_exit_bit, 1'b0);
      db_exit_wr = 1; tick(1); db_exit_wr = 0;
      bat_recovered = 1; tick(1); bat_recovered = 0;
      chk("R10 recovery clears", db_exit_bit, 1'b0);

      // R11 start accepted again
      db_start = 1; tick(1); db_start = 0;
      chk("R11 start accepted", db_mode, 1'b1);

      // R12 VBUS removal withdraws charging
      vbus_raw = 1; tick(DEB + SYNC + 1);
      chk("R12 charge on", chg_keep_en, 1'b1);
      vbus_raw = 0; tick(DEB + SYNC + 2);
      chk("R12 charge off", chg_keep_en, 1'b0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule